// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block holds the interrupt source logic for a group of GPIO pins. Each pin has a 32-bit control word and a filtered input level. From these the block detects level or edge events and keeps a sticky interrupt status bit and a sticky wake status bit for each pin. It also raises a pending line toward the interrupt aggregator whenever either status bit is set and the pin is unmasked. Software clears each status bit with a one-cycle clear pulse, which acts as a write-one-to-clear. The block also returns the sampled pin level and drives the pad output-enable and output-value bits straight from the control word.

Detection is armed by an enable bit, and reporting is gated by a separate mask bit. A pin can therefore collect status while it is masked and report it later. Wake status is recorded only for the sleep state named on the power-state input, and only when that state's per-pin wake enable is set.

Top module: `gpio_irq_det`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every interrupt status, wake status and pending output is 0.
- R2: With control bit 0 (trigger type) at 0, edge mode, and the 2-bit active field in bits 2:1 at 0, a rising level sets the interrupt status one clock later. A falling level does not set it.
- R3: In edge mode with the active field at 1, a falling level sets the interrupt status, and a rising level does not.
- R4: In edge mode with the active field at 2, both rising and falling levels set the interrupt status.
- R5: With trigger type 1, level mode, the status is set on every clock where the level is active: high for field 0, low for field 1. It stays set through a clear pulse for as long as the level persists.
- R6: Level mode with the active field at 2 or 3, and edge mode with the field at 3, never set any status.
- R7: While the enable bit (bit 3) is 0, no event is detected. A status bit that is already set stays set.
- R8: A clear pulse on clr_irq_i or clr_wake_i clears that pin's status bit on the next clock. If a new event arrives in the same clock, the set wins. Other pins are not affected.
- R9: pending_o for a pin is 1 exactly when that pin's interrupt or wake status is set and its unmask bit (bit 4) is 1.
- R10: A detected event sets the wake status only when sleep_state_i is 1, 2 or 3 and the pin's wake enable for that state is set. The wake enable for state 1 is bit 5, for state 2 bit 6, and for state 3 bit 7. In state 0 no wake status is set.
- R11: pin_sts_o is pin_lvl_i delayed by one clock. pad_oe_o equals control bit 8 and pad_out_o equals control bit 9.
- R12: No edge is detected in the first clock after reset, even if the level sampled during reset differs from the level at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | NPINS | Filtered pin levels |
| cfg_i | input | NPINS*32 | Control words, pin p at bits p*32 +: 32 |
| clr_irq_i | input | NPINS | Clear pulse for interrupt status |
| clr_wake_i | input | NPINS | Clear pulse for wake status |
| sleep_state_i | input | 2 | 0 run, 1/2/3 sleep states selecting wake enables |
| irq_sts_o | output | NPINS | Sticky interrupt status |
| wake_sts_o | output | NPINS | Sticky wake status |
| pending_o | output | NPINS | Unmasked pending toward aggregator |
| pin_sts_o | output | NPINS | Registered pin level |
| pad_oe_o | output | NPINS | Pad output enable |
| pad_out_o | output | NPINS | Pad output value |

## Verification
The detector is driven with single rising and falling steps in every active-field encoding. These show whether the block tells edge polarity apart and whether it handles the both-edges code. Held levels in level mode, combined with clear pulses, separate the status that re-arms while the level persists from the edge status that stays clear. The illegal encodings, a disabled pin, a masked pin and a clear pulse arriving in the same clock as an event each separate the detect stage, the sticky stage and the report stage. The power-state input is swept over enabled and non-enabled states to show that wake status depends on both the state and the per-pin wake bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CFG_W = 32;

  typedef enum logic [1:0] {
    ACT_HIGH = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_BOTH = 2'd2,
    ACT_RSVD = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_S0I3 = 2'd1,
    PWR_S3   = 2'd2,
    PWR_S45  = 2'd3
  } pwr_e;

  typedef struct packed {
    logic [21:0] rsvd;
    logic        out_val;
    logic        out_en;
    logic        wake_s45;
    logic        wake_s3;
    logic        wake_s0i3;
    logic        unmask;
    logic        irq_en;
    act_e        act;
    logic        lvl_trig;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic lvl_trig_i,
  input  act_e act_i,
  input  logic en_i,
  output logic hit_o,
  output logic lvl_q_o
);
  logic prev_q, primed_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  // no edge until a real previous sample exists
  assign rise = primed_q & lvl_i & ~prev_q;
  assign fall = primed_q & ~lvl_i & prev_q;

  always_comb begin
    hit_o = 1'b0;
    if (en_i) begin
      if (lvl_trig_i) begin
        unique case (act_i)
          ACT_HIGH: hit_o = lvl_i;
          ACT_LOW:  hit_o = ~lvl_i;
          default:  hit_o = 1'b0;
        endcase
      end else begin
        unique case (act_i)
          ACT_HIGH: hit_o = rise;
          ACT_LOW:  hit_o = fall;
          ACT_BOTH: hit_o = rise | fall;
          default:  hit_o = 1'b0;
        endcase
      end
    end
  end

  assign lvl_q_o = prev_q;
endmodule

// File: rtl/gpio_irq_wake_sel.sv
module gpio_irq_wake_sel
  import gpio_irq_pkg::*;
(
  input  pwr_e pwr_i,
  input  logic wk_s0i3_i,
  input  logic wk_s3_i,
  input  logic wk_s45_i,
  output logic wake_en_o
);
  always_comb begin
    unique case (pwr_i)
      PWR_S0I3: wake_en_o = wk_s0i3_i;
      PWR_S3:   wake_en_o = wk_s3_i;
      PWR_S45:  wake_en_o = wk_s45_i;
      default:  wake_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_sticky.sv
module gpio_irq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_irq_i,
  input  logic set_wake_i,
  input  logic clr_irq_i,
  input  logic clr_wake_i,
  output logic irq_q_o,
  output logic wake_q_o
);
  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q_o  <= 1'b0;
      wake_q_o <= 1'b0;
    end else begin
      irq_q_o  <= set_irq_i  | (irq_q_o  & ~clr_irq_i);
      wake_q_o <= set_wake_i | (wake_q_o & ~clr_wake_i);
    end
  end
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NPINS-1:0]       pin_lvl_i,
  input  logic [NPINS*CFG_W-1:0] cfg_i,
  input  logic [NPINS-1:0]       clr_irq_i,
  input  logic [NPINS-1:0]       clr_wake_i,
  input  logic [1:0]             sleep_state_i,
  output logic [NPINS-1:0]       irq_sts_o,
  output logic [NPINS-1:0]       wake_sts_o,
  output logic [NPINS-1:0]       pending_o,
  output logic [NPINS-1:0]       pin_sts_o,
  output logic [NPINS-1:0]       pad_oe_o,
  output logic [NPINS-1:0]       pad_out_o
);
  pwr_e pwr;
  assign pwr = pwr_e'(sleep_state_i);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_cfg_t cfg;
    logic     hit, wake_en;
    logic     unused_rsvd;

    assign cfg         = pin_cfg_t'(cfg_i[p*CFG_W +: CFG_W]);
    assign unused_rsvd = ^cfg.rsvd;

    gpio_irq_trig u_trig (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (pin_lvl_i[p]),
      .lvl_trig_i (cfg.lvl_trig),
      .act_i      (cfg.act),
      .en_i       (cfg.irq_en),
      .hit_o      (hit),
      .lvl_q_o    (pin_sts_o[p])
    );

    gpio_irq_wake_sel u_wsel (
      .pwr_i     (pwr),
      .wk_s0i3_i (cfg.wake_s0i3),
      .wk_s3_i   (cfg.wake_s3),
      .wk_s45_i  (cfg.wake_s45),
      .wake_en_o (wake_en)
    );

    gpio_irq_sticky u_sticky (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_irq_i  (hit),
      .set_wake_i (hit & wake_en),
      .clr_irq_i  (clr_irq_i[p]),
      .clr_wake_i (clr_wake_i[p]),
      .irq_q_o    (irq_sts_o[p]),
      .wake_q_o   (wake_sts_o[p])
    );

    assign pending_o[p] = (irq_sts_o[p] | wake_sts_o[p]) & cfg.unmask;
    assign pad_oe_o[p]  = cfg.out_en;
    assign pad_out_o[p] = cfg.out_val;
  end
endmodule

// File: rtl/gpio_irq_det_chk.sv
module gpio_irq_det_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NPINS-1:0]       pin_lvl_i,
  input logic [NPINS*CFG_W-1:0] cfg_i,
  input logic [NPINS-1:0]       clr_irq_i,
  input logic [1:0]             sleep_state_i,
  input logic [NPINS-1:0]       irq_sts_o,
  input logic [NPINS-1:0]       wake_sts_o,
  input logic [NPINS-1:0]       pending_o,
  input logic [NPINS-1:0]       pin_sts_o
);
  logic unused_cfg;
  assign unused_cfg = ^cfg_i;

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    logic en, um, lt;
    logic [1:0] act;
    assign lt  = cfg_i[p*CFG_W + 0];
    assign act = cfg_i[p*CFG_W + 1 +: 2];
    assign en  = cfg_i[p*CFG_W + 3];
    assign um  = cfg_i[p*CFG_W + 4];

    AST_RST_IDLE: assert property (@(posedge clk_i) !rst_ni |-> (irq_sts_o[p] == 1'b0 && wake_sts_o[p] == 1'b0)) else $error("rst idle"); // R1
    AST_LVL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) (lt && en && act == 2'd0 && pin_lvl_i[p]) |=> irq_sts_o[p]) else $error("level set"); // R5
    AST_DIS_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (!irq_sts_o[p] && !en) |=> !irq_sts_o[p]) else $error("disabled set"); // R7
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (irq_sts_o[p] && !clr_irq_i[p]) |=> irq_sts_o[p]) else $error("sticky lost"); // R8
    AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_irq_i[p] && !en) |=> !irq_sts_o[p]) else $error("clear failed"); // R8
    AST_PEND_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni) pending_o[p] |-> (um && (irq_sts_o[p] || wake_sts_o[p]))) else $error("pending"); // R9
    AST_WAKE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni) (sleep_state_i == 2'd0 && !wake_sts_o[p]) |=> !wake_sts_o[p]) else $error("wake in run"); // R10
    AST_PIN_STS: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> (pin_sts_o[p] == $past(pin_lvl_i[p]))) else $error("pin sts"); // R11
  end
endmodule

bind gpio_irq_det gpio_irq_det_chk #(.NPINS(NPINS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pin_lvl_i     (pin_lvl_i),
  .cfg_i         (cfg_i),
  .clr_irq_i     (clr_irq_i),
  .sleep_state_i (sleep_state_i),
  .irq_sts_o     (irq_sts_o),
  .wake_sts_o    (wake_sts_o),
  .pending_o     (pending_o),
  .pin_sts_o     (pin_sts_o)
);

// File: tb/gpio_irq_det_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_det_tb_top;
  localparam int NP = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NP-1:0]   pin_lvl_i = '0;
  logic [NP*32-1:0] cfg_i;
  logic [NP-1:0]   clr_irq_i = '0;
  logic [NP-1:0]   clr_wake_i = '0;
  logic [1:0]      sleep_state_i = 2'd0;
  logic [NP-1:0]   irq_sts_o, wake_sts_o, pending_o, pin_sts_o, pad_oe_o, pad_out_o;
  logic [31:0]     cfg_w [NP];

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  always_comb
    for (int i = 0; i < NP; i++) cfg_i[i*32 +: 32] = cfg_w[i];

  gpio_irq_det #(.NPINS(NP)) dut_i (.*);

  function automatic logic [31:0] mk(bit lt, bit [1:0] act, bit en, bit um,
                                     bit [2:0] wk, bit oe, bit ov);
    return {22'd0, ov, oe, wk[2], wk[1], wk[0], um, en, act, lt};
  endfunction

  task automatic chk(string req, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  task automatic quiet;
    for (int i = 0; i < NP; i++) cfg_w[i] = '0;
    pin_lvl_i  = '0;
    sleep_state_i = 2'd0;
    clr_irq_i  = '1;
    clr_wake_i = '1;
    tick();
    clr_irq_i  = '0;
    clr_wake_i = '0;
    tick();
  endtask

  task automatic t_reset;
    cfg_w[0] = mk(0, 2'd0, 1, 1, 3'b000, 0, 0);
    pin_lvl_i[0] = 1'b1;
    repeat (3) tick();
    chk("R1", "irq in reset", |irq_sts_o, 1'b0);
    chk("R1", "pending in reset", |pending_o, 1'b0);
    rst_ni = 1'b1;
    tick();
    chk("R12", "no edge first cycle", irq_sts_o[0], 1'b0);
    chk("R1", "wake after reset", |wake_sts_o, 1'b0);
    tick();
    chk("R12", "still idle", irq_sts_o[0], 1'b0);
  endtask

  task automatic t_rise;
    quiet();
    cfg_w[1] = mk(0, 2'd0, 1, 1, 3'b000, 0, 0);
    tick();
    pin_lvl_i[1] = 1'b1; tick();
    chk("R2", "rise sets", irq_sts_o[1], 1'b1);
    clr_irq_i[1] = 1'b1; tick(); clr_irq_i[1] = 1'b0;
    chk("R2", "cleared while high", irq_sts_o[1], 1'b0);
    pin_lvl_i[1] = 1'b0; tick();
    chk("R2", "fall ignored", irq_sts_o[1], 1'b0);
  endtask

  task automatic t_fall;
    quiet();
    cfg_w[2] = mk(0, 2'd1, 1, 1, 3'b000, 0, 0);
    pin_lvl_i[2] = 1'b1; tick(); tick();
    chk("R3", "rise ignored", irq_sts_o[2], 1'b0);
    pin_lvl_i[2] = 1'b0; tick();
    chk("R3", "fall sets", irq_sts_o[2], 1'b1);
  endtask

  task automatic t_both;
    quiet();
    cfg_w[3] = mk(0, 2'd2, 1, 1, 3'b000, 0, 0);
    pin_lvl_i[3] = 1'b1; tick();
    chk("R4", "both rise", irq_sts_o[3], 1'b1);
    clr_irq_i[3] = 1'b1; tick(); clr_irq_i[3] = 1'b0;
    chk("R4", "cleared", irq_sts_o[3], 1'b0);
    pin_lvl_i[3] = 1'b0; tick();
    chk("R4", "both fall", irq_sts_o[3], 1'b1);
  endtask

  task automatic t_level;
    quiet();
    cfg_w[0] = mk(1, 2'd0, 1, 1, 3'b000, 0, 0);
    pin_lvl_i[0] = 1'b1; tick();
    chk("R5", "high level sets", irq_sts_o[0], 1'b1);
    clr_irq_i[0] = 1'b1; tick(); clr_irq_i[0] = 1'b0;
    chk("R5", "re-set while high", irq_sts_o[0], 1'b1);
    pin_lvl_i[0] = 1'b0; clr_irq_i[0] = 1'b1; tick(); clr_irq_i[0] = 1'b0;
    chk("R5", "cleared after release", irq_sts_o[0], 1'b0);
    cfg_w[0] = mk(1, 2'd1, 1, 1, 3'b000, 0, 0); tick();
    chk("R5", "low level sets", irq_sts_o[0], 1'b1);
  endtask

  task automatic t_illegal;
    quiet();
    cfg_w[1] = mk(1, 2'd2, 1, 1, 3'b000, 0, 0);
    cfg_w[2] = mk(1, 2'd3, 1, 1, 3'b000, 0, 0);
    cfg_w[3] = mk(0, 2'd3, 1, 1, 3'b000, 0, 0);
    pin_lvl_i = 4'b1110; tick(); tick();
    pin_lvl_i = 4'b0000; tick(); tick();
    chk("R6", "level both", irq_sts_o[1], 1'b0);
    chk("R6", "level rsvd", irq_sts_o[2], 1'b0);
    chk("R6", "edge rsvd", irq_sts_o[3], 1'b0);
  endtask

  task automatic t_enable;
    quiet();
    cfg_w[1] = mk(0, 2'd0, 0, 1, 3'b000, 0, 0);
    pin_lvl_i[1] = 1'b1; tick();
    chk("R7", "disabled rise", irq_sts_o[1], 1'b0);
    pin_lvl_i[1] = 1'b0; cfg_w[1] = mk(0, 2'd2, 1, 1, 3'b000, 0, 0); tick();
    chk("R7", "enabled fall", irq_sts_o[1], 1'b1);
    cfg_w[1] = mk(0, 2'd2, 0, 1, 3'b000, 0, 0);
    pin_lvl_i[1] = 1'b1; tick(); tick();
    chk("R7", "status kept while disabled", irq_sts_o[1], 1'b1);
  endtask

  task automatic t_w1c;
    quiet();
    cfg_w[0] = mk(0, 2'd0, 1, 1, 3'b000, 0, 0);
    cfg_w[2] = mk(0, 2'd0, 1, 1, 3'b000, 0, 0);
    pin_lvl_i = 4'b0101; tick();
    pin_lvl_i = 4'b0000; tick();
    pin_lvl_i[0] = 1'b1; clr_irq_i[0] = 1'b1; tick(); clr_irq_i[0] = 1'b0;
    chk("R8", "set wins over clear", irq_sts_o[0], 1'b1);
    clr_irq_i[0] = 1'b1; tick(); clr_irq_i[0] = 1'b0;
    chk("R8", "clear alone", irq_sts_o[0], 1'b0);
    chk("R8", "neighbour untouched", irq_sts_o[2], 1'b1);
  endtask

  task automatic t_mask;
    quiet();
    cfg_w[3] = mk(0, 2'd0, 1, 0, 3'b000, 0, 0);
    pin_lvl_i[3] = 1'b1; tick();
    chk("R9", "masked status", irq_sts_o[3], 1'b1);
    chk("R9", "masked pending", pending_o[3], 1'b0);
    cfg_w[3] = mk(0, 2'd0, 1, 1, 3'b000, 0, 0); #1;
    chk("R9", "unmasked pending", pending_o[3], 1'b1);
  endtask

  task automatic t_wake;
    quiet();
    sleep_state_i = 2'd2;
    cfg_w[2] = mk(0, 2'd0, 1, 1, 3'b010, 0, 0);
    pin_lvl_i[2] = 1'b1; tick();
    chk("R10", "wake s3", wake_sts_o[2], 1'b1);
    clr_irq_i[2] = 1'b1; tick(); clr_irq_i[2] = 1'b0;
    chk("R10", "pending from wake only", pending_o[2], 1'b1);
    clr_wake_i[2] = 1'b1; tick(); clr_wake_i[2] = 1'b0;
    chk("R10", "wake cleared", wake_sts_o[2], 1'b0);
    sleep_state_i = 2'd1;
    pin_lvl_i[2] = 1'b0; tick(); pin_lvl_i[2] = 1'b1; tick();
    chk("R10", "state not enabled", wake_sts_o[2], 1'b0);
    sleep_state_i = 2'd0; cfg_w[2] = mk(0, 2'd0, 1, 1, 3'b111, 0, 0);
    pin_lvl_i[2] = 1'b0; tick(); pin_lvl_i[2] = 1'b1; tick();
    chk("R10", "run state no wake", wake_sts_o[2], 1'b0);
    chk("R10", "run state irq", irq_sts_o[2], 1'b1);
    sleep_state_i = 2'd3; cfg_w[2] = mk(0, 2'd0, 1, 1, 3'b100, 0, 0);
    pin_lvl_i[2] = 1'b0; tick(); pin_lvl_i[2] = 1'b1; tick();
    chk("R10", "wake s45", wake_sts_o[2], 1'b1);
  endtask

  task automatic t_pad;
    quiet();
    pin_lvl_i[1] = 1'b1; #1;
    chk("R11", "pin sts delayed", pin_sts_o[1], 1'b0);
    tick();
    chk("R11", "pin sts follows", pin_sts_o[1], 1'b1);
    cfg_w[1] = mk(0, 2'd0, 0, 0, 3'b000, 1, 1); #1;
    chk("R11", "pad oe", pad_oe_o[1], 1'b1);
    chk("R11", "pad out", pad_out_o[1], 1'b1);
    cfg_w[1] = mk(0, 2'd0, 0, 0, 3'b000, 1, 0); #1;
    chk("R11", "pad out low", pad_out_o[1], 1'b0);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) cfg_w[i] = '0;
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_illegal();
    t_enable();
    t_w1c();
    t_mask();
    t_wake();
    t_pad();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule